// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Overflow Flag

This block is a 32-bit arithmetic unit in which no operation wraps around. If a result does not fit its target range, the unit clamps it to the nearest representable limit. It provides the following operations:

- signed and unsigned add;
- signed and unsigned subtract;
- a signed doubling;
- clamping of a word to a chosen bit position, in signed or unsigned form;
- the same bit-position clamping applied to each 16-bit half of the word separately.

Every clamp raises a single sticky overflow flag. All operations share this flag. It stays raised until a dedicated clear strobe drops it.

The operands, operation code, bit position and clear strobe are sampled on every rising clock edge. The result and the flag are registered, so both appear one cycle after the inputs that produced them. The surrounding datapath reads the flag after a run of operations to learn whether any of them lost precision.

Top module: `sat_alu`

## Requirements
- R1: Code 1 (signed add): if both operands have the same sign and the sum's sign differs, the result is 0x7FFFFFFF when `op_a` is non-negative and 0x80000000 otherwise. Otherwise the result is the wrapped sum.
- R2: Code 3 (signed subtract `op_a - op_b`): if the operands differ in sign and the difference's sign differs from `op_a`, the result clamps as in R1 (by the sign of `op_a`). Otherwise the result is the difference.
- R3: Code 2 (unsigned add): a sum that exceeds 32 bits gives 0xFFFFFFFF.
- R4: Code 4 (unsigned subtract): when `op_b > op_a` the result is 0. Otherwise the result is `op_a - op_b`.
- R5: Code 5 (signed doubling of `op_a`): an input of 0x40000000 or more (signed) gives 0x7FFFFFFF. An input of 0xC0000000 or less gives 0x80000000, and this case counts as a clamp. Any other input gives `op_a << 1`.
- R6: Code 6 (signed clamp of `op_a` to position N = `sat_pos`): the result is limited to the range [-(2^N), 2^N-1].
- R7: Code 7 (unsigned clamp of `op_a` to position N): negative inputs give 0, and inputs above 2^N-1 give 2^N-1.
- R8: Codes 8 (signed) and 9 (unsigned) take bits [15:0] and [31:16] of `op_a` as signed 16-bit values. Each half is clamped on its own as in R6/R7, and the low 16 bits of each half's result are packed into the result at that half's position.
- R9: Any clamp sets `sticky`. An operation that does not clamp leaves `sticky` unchanged.
- R10: Only `flag_clr` clears `sticky`. A clear in the same cycle as a clamp leaves `sticky` set.
- R11: The result and flag of the inputs at one rising edge are visible after that edge. Reset drives `result` to 0 and `sticky` to 0.
- R12: Code 0 and codes 10 to 15 pass `op_a` through unchanged and never clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (add and subtract only) |
| op_sel | input | 4 | Operation code |
| sat_pos | input | 5 | Bit position N for codes 6 to 9 |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| result | output | 32 | Registered result |
| sticky | output | 1 | Sticky overflow flag |

## Verification
The bench builds the unit with its default 32-bit width, so 16-bit halves and a 5-bit position field. The exact signed limits therefore sit at 0x7FFFFFFF and 0x80000000, and the doubling thresholds at 0x40000000 and 0xC0000000. This lets the bench aim directly at the one-off-the-limit operands.

The position field reaches both ends of its range: N of 0 gives the narrowest clamp, and N of 31 means a signed full-word clamp can never fire. In the halfword forms, positions of 15 and above stop the signed clamp from firing. This exercises the condition where one half clamps and the other does not.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [3:0] {
    OP_PASS   = 4'd0,
    OP_SADD   = 4'd1,
    OP_UADD   = 4'd2,
    OP_SSUB   = 4'd3,
    OP_USUB   = 4'd4,
    OP_SDBL   = 4'd5,
    OP_SCLAMP = 4'd6,
    OP_UCLAMP = 4'd7,
    OP_SDUAL  = 4'd8,
    OP_UDUAL  = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_sub,
  input  logic         is_uns,
  output logic [W-1:0] res,
  output logic         clamp
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  // wide result: bit W is carry (add) or borrow (sub) in the unsigned view
  function automatic logic [W:0] wide_op(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic sub);
    if (sub) return {1'b0, x} - {1'b0, y};
    else     return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic signed_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                      input logic [W-1:0] r, input logic sub);
    logic same_in;
    same_in = (x[W-1] == y[W-1]);
    return (sub ? !same_in : same_in) && (r[W-1] != x[W-1]);
  endfunction

  logic [W:0] wide;
  logic       s_ovf;
  logic       u_ovf;

  always_comb begin
    wide  = wide_op(a, b, is_sub);
    s_ovf = signed_ovf(a, b, wide[W-1:0], is_sub);
    u_ovf = wide[W];
    res   = wide[W-1:0];
    clamp = 1'b0;
    if (is_uns) begin
      if (u_ovf) begin
        clamp = 1'b1;
        res   = is_sub ? '0 : '1;
      end
    end else if (s_ovf) begin
      clamp = 1'b1;
      res   = a[W-1] ? SMIN : SMAX;
    end
  end
endmodule

// File: rtl/sat_double.sv
module sat_double #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic         clamp
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  // at or above one quarter of the range (positive)
  function automatic logic too_high(input logic [W-1:0] x);
    return !x[W-1] && x[W-2];
  endfunction

  // at or below minus one quarter: either bit W-2 clear, or exactly the quarter point
  function automatic logic too_low(input logic [W-1:0] x);
    return x[W-1] && (!x[W-2] || (x[W-3:0] == '0));
  endfunction

  always_comb begin
    clamp = 1'b0;
    res   = {a[W-2:0], 1'b0};
    if (too_high(a)) begin
      clamp = 1'b1;
      res   = SMAX;
    end else if (too_low(a)) begin
      clamp = 1'b1;
      res   = SMIN;
    end
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W   = 32,
  parameter int PW  = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [PW-1:0] pos,
  input  logic          is_uns,
  output logic [W-1:0]  res,
  output logic          clamp
);
  function automatic logic [W-1:0] low_mask(input logic [PW-1:0] n);
    return ~({W{1'b1}} << n);
  endfunction

  logic [W-1:0] mask;
  logic [W-1:0] top;
  logic         s_hi, s_lo, u_neg, u_hi;

  always_comb begin
    mask  = low_mask(pos);
    top   = $unsigned($signed(val) >>> pos);
    s_hi  = !top[W-1] && (top != '0);
    s_lo  = top[W-1] && (top != '1);
    u_neg = val[W-1];
    u_hi  = !val[W-1] && ((val & ~mask) != '0);
    clamp = 1'b0;
    res   = val;
    if (is_uns) begin
      if (u_neg) begin
        clamp = 1'b1;
        res   = '0;
      end else if (u_hi) begin
        clamp = 1'b1;
        res   = mask;
      end
    end else begin
      if (s_hi) begin
        clamp = 1'b1;
        res   = mask;
      end else if (s_lo) begin
        clamp = 1'b1;
        res   = ~mask;
      end
    end
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [3:0]    op_sel,
  input  logic [PW-1:0] sat_pos,
  input  logic          flag_clr,
  output logic [W-1:0]  result,
  output logic          sticky
);
  import sat_pkg::*;

  localparam int H     = W / 2;
  localparam int LANES = 2;

  // named internal events for the checker
  logic [W-1:0] as_res;
  logic         as_clamp;
  logic [W-1:0] dbl_res;
  logic         dbl_clamp;
  logic [W-1:0] wc_res;
  logic         wc_clamp;
  logic [W-1:0] dual_res;
  logic         dual_clamp;
  logic [LANES-1:0] lane_clamp;
  logic [W-1:0] next_res;
  logic         clamp_evt;

  logic is_sub, is_uns_as, is_uns_cl;
  assign is_sub    = (op_sel == OP_SSUB) || (op_sel == OP_USUB);
  assign is_uns_as = (op_sel == OP_UADD) || (op_sel == OP_USUB);
  assign is_uns_cl = (op_sel == OP_UCLAMP) || (op_sel == OP_UDUAL);

  sat_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(op_b), .is_sub(is_sub), .is_uns(is_uns_as),
    .res(as_res), .clamp(as_clamp)
  );

  sat_double #(.W(W)) u_double (
    .a(op_a), .res(dbl_res), .clamp(dbl_clamp)
  );

  sat_clamp #(.W(W), .PW(PW)) u_word (
    .val(op_a), .pos(sat_pos), .is_uns(is_uns_cl),
    .res(wc_res), .clamp(wc_clamp)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [W-1:0] lane_in;
      logic [W-1:0] lane_out;
      assign lane_in = {{(W-H){op_a[g*H+H-1]}}, op_a[g*H +: H]};
      sat_clamp #(.W(W), .PW(PW)) u_half (
        .val(lane_in), .pos(sat_pos), .is_uns(is_uns_cl),
        .res(lane_out), .clamp(lane_clamp[g])
      );
      assign dual_res[g*H +: H] = lane_out[H-1:0];
    end
  endgenerate

  assign dual_clamp = |lane_clamp;

  always_comb begin
    next_res  = op_a;
    clamp_evt = 1'b0;
    case (op_sel)
      OP_SADD, OP_UADD, OP_SSUB, OP_USUB: begin
        next_res  = as_res;
        clamp_evt = as_clamp;
      end
      OP_SDBL: begin
        next_res  = dbl_res;
        clamp_evt = dbl_clamp;
      end
      OP_SCLAMP, OP_UCLAMP: begin
        next_res  = wc_res;
        clamp_evt = wc_clamp;
      end
      OP_SDUAL, OP_UDUAL: begin
        next_res  = dual_res;
        clamp_evt = dual_clamp;
      end
      default: begin
        next_res  = op_a;
        clamp_evt = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      sticky <= 1'b0;
    end else begin
      result <= next_res;
      sticky <= clamp_evt | (sticky & ~flag_clr);
    end
  end
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int W  = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [3:0]   op_sel,
  input logic         flag_clr,
  input logic         clamp_evt,
  input logic [W-1:0] result,
  input logic         sticky
);
  // R9: a clamp always leaves the flag raised
  assert_clamp_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_evt |=> sticky);

  // R9: without clamp or clear the flag holds
  assert_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clamp_evt && !flag_clr) |=> (sticky == $past(sticky)));

  // R10: a clear without a clamp drops the flag
  assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !clamp_evt) |=> !sticky);

  // R3: unsigned add clamp yields all ones
  assert_uadd_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd2 && clamp_evt) |=> (result == '1));

  // R4: unsigned subtract clamp yields zero
  assert_usub_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd4 && clamp_evt) |=> (result == '0));

  // R12: pass codes never clamp and forward op_a
  assert_pass_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd0 || op_sel > 4'd9) |=> (result == $past(op_a)));

  assert_pass_noclamp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd0 || op_sel > 4'd9) |-> !clamp_evt);
endmodule

bind sat_alu sat_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_sel(op_sel),
  .flag_clr(flag_clr), .clamp_evt(clamp_evt), .result(result), .sticky(sticky)
);

// File: tb/sat_alu_test.sv
module sat_alu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  op_sel = '0;
  logic [4:0]  sat_pos = '0;
  logic        flag_clr = 1'b0;
  logic [31:0] result;
  logic        sticky;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_flag = 1'b0;
  bit finished = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_alu uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .sat_pos(sat_pos), .flag_clr(flag_clr), .result(result), .sticky(sticky)
  );

  // reference clamp over a wide integer range
  function automatic void ref_clamp(input longint v, input int n, input bit uns,
                                    output longint r, output bit s);
    longint lo, hi;
    hi = (longint'(1) << n) - 1;
    lo = uns ? 0 : -(longint'(1) << n);
    s = 1'b1;
    if (v > hi) r = hi;
    else if (v < lo) r = lo;
    else begin r = v; s = 1'b0; end
  endfunction

  function automatic void model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic [4:0] n, output logic [31:0] r, output bit s);
    longint sa, sb, ua, ub, t, r0, r1;
    bit s0, s1;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'({32'b0, a}); ub = longint'({32'b0, b});
    s = 1'b0; r = a;
    case (op)
      4'd1, 4'd3: begin
        t = (op == 4'd1) ? sa + sb : sa - sb;
        if (t > 64'sd2147483647) begin r = 32'h7FFF_FFFF; s = 1'b1; end
        else if (t < -64'sd2147483648) begin r = 32'h8000_0000; s = 1'b1; end
        else r = t[31:0];
      end
      4'd2: begin
        t = ua + ub;
        if (t > 64'sd4294967295) begin r = '1; s = 1'b1; end else r = t[31:0];
      end
      4'd4: begin
        if (ub > ua) begin r = '0; s = 1'b1; end else begin t = ua - ub; r = t[31:0]; end
      end
      4'd5: begin
        if (sa >= 64'sd1073741824) begin r = 32'h7FFF_FFFF; s = 1'b1; end
        else if (sa <= -64'sd1073741824) begin r = 32'h8000_0000; s = 1'b1; end
        else begin t = sa * 2; r = t[31:0]; end
      end
      4'd6, 4'd7: begin
        ref_clamp(sa, int'(n), op == 4'd7, t, s);
        r = t[31:0];
      end
      4'd8, 4'd9: begin
        ref_clamp(longint'($signed(a[15:0])), int'(n), op == 4'd9, r0, s0);
        ref_clamp(longint'($signed(a[31:16])), int'(n), op == 4'd9, r1, s1);
        r = {r1[15:0], r0[15:0]};
        s = s0 | s1;
      end
      default: begin r = a; s = 1'b0; end
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] exp_r, input bit exp_s);
    n_chk++;
    if (result !== exp_r || sticky !== exp_s) begin
      n_bad++;
      $display("FAIL %s: result=%h sticky=%b expected result=%h sticky=%b",
               tag, result, sticky, exp_r, exp_s);
    end
  endtask

  // drive one operation, wait for its edge, compare
  task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] n, input bit clr);
    logic [31:0] er;
    bit es;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; sat_pos = n; flag_clr = clr;
    model(op, a, b, n, er, es);
    exp_flag = es | (exp_flag & ~clr);
    @(posedge clk); #1;
    check(tag, er, exp_flag);
  endtask

  task automatic clear_flag();
    run_op("R10 clear", 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R11 reset", 32'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_signed_add();
    clear_flag();
    run_op("R1 no ovf", 4'd1, 32'h0000_0005, 32'hFFFF_FFFD, 5'd0, 1'b0);
    run_op("R1 pos ovf", 4'd1, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, 1'b0);
    clear_flag();
    run_op("R1 neg ovf", 4'd1, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, 1'b0);
    run_op("R1 mixed sign", 4'd1, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, 1'b0);
  endtask

  task automatic t_signed_sub();
    clear_flag();
    run_op("R2 no ovf", 4'd3, 32'h8000_0001, 32'h0000_0001, 5'd0, 1'b0);
    run_op("R2 neg ovf", 4'd3, 32'h8000_0000, 32'h0000_0001, 5'd0, 1'b0);
    clear_flag();
    run_op("R2 pos ovf", 4'd3, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b0);
    run_op("R2 zero minus min", 4'd3, 32'h0, 32'h8000_0000, 5'd0, 1'b0);
  endtask

  task automatic t_unsigned();
    clear_flag();
    run_op("R3 fits", 4'd2, 32'hFFFF_FFFE, 32'h1, 5'd0, 1'b0);
    run_op("R3 wraps", 4'd2, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b0);
    clear_flag();
    run_op("R4 equal", 4'd4, 32'h55, 32'h55, 5'd0, 1'b0);
    run_op("R4 borrow", 4'd4, 32'h54, 32'h55, 5'd0, 1'b0);
  endtask

  task automatic t_double();
    clear_flag();
    run_op("R5 below hi", 4'd5, 32'h3FFF_FFFF, 32'h0, 5'd0, 1'b0);
    run_op("R5 above lo", 4'd5, 32'hC000_0001, 32'h0, 5'd0, 1'b0);
    run_op("R5 at hi", 4'd5, 32'h4000_0000, 32'h0, 5'd0, 1'b0);
    clear_flag();
    run_op("R5 at lo", 4'd5, 32'hC000_0000, 32'h0, 5'd0, 1'b0);
  endtask

  task automatic t_word_clamp();
    clear_flag();
    run_op("R6 in range", 4'd6, 32'h0000_00FF, 32'h0, 5'd8, 1'b0);
    run_op("R6 above", 4'd6, 32'h0000_0100, 32'h0, 5'd8, 1'b0);
    run_op("R6 below", 4'd6, 32'hFFFF_FEFF, 32'h0, 5'd8, 1'b0);
    clear_flag();
    run_op("R6 n0", 4'd6, 32'hFFFF_FFFF, 32'h0, 5'd0, 1'b0);
    run_op("R6 n31 min", 4'd6, 32'h8000_0000, 32'h0, 5'd31, 1'b0);
    run_op("R7 negative", 4'd7, 32'hFFFF_FFF0, 32'h0, 5'd4, 1'b0);
    clear_flag();
    run_op("R7 top", 4'd7, 32'h0000_000F, 32'h0, 5'd4, 1'b0);
    run_op("R7 above", 4'd7, 32'h0000_0010, 32'h0, 5'd4, 1'b0);
  endtask

  task automatic t_dual();
    clear_flag();
    run_op("R8 signed one half", 4'd8, 32'h0100_0005, 32'h0, 5'd7, 1'b0);
    clear_flag();
    run_op("R8 signed neg low", 4'd8, 32'h0003_FF00, 32'h0, 5'd3, 1'b0);
    clear_flag();
    run_op("R8 signed n15", 4'd8, 32'h8000_7FFF, 32'h0, 5'd15, 1'b0);
    run_op("R8 unsigned", 4'd9, 32'hFFFF_0123, 32'h0, 5'd8, 1'b0);
    clear_flag();
    run_op("R8 unsigned fit", 4'd9, 32'h00FF_0010, 32'h0, 5'd8, 1'b0);
  endtask

  task automatic t_sticky();
    clear_flag();
    run_op("R9 set", 4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b0);
    run_op("R9 hold add", 4'd1, 32'h1, 32'h1, 5'd0, 1'b0);
    run_op("R9 hold pass", 4'd0, 32'hABCD_0001, 32'h0, 5'd0, 1'b0);
    run_op("R10 clear with clamp", 4'd4, 32'h0, 32'h1, 5'd0, 1'b1);
    run_op("R10 plain clear", 4'd1, 32'h2, 32'h3, 5'd0, 1'b1);
    run_op("R10 stays clear", 4'd0, 32'h1, 32'h0, 5'd0, 1'b0);
  endtask

  task automatic t_pass();
    run_op("R12 code0", 4'd0, 32'hDEAD_BEEF, 32'h1, 5'd3, 1'b0);
    for (int c = 10; c < 16; c++)
      run_op("R12 spare code", c[3:0], 32'h8000_0000 ^ c, 32'hFFFF_FFFF, 5'd0, 1'b0);
  endtask

  task automatic t_mix();
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      a = rng;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      b = rng;
      run_op("R11 mixed", a[3:0] % 4'd10, a, b, b[4:0], b[31] & b[30]);
    end
  endtask

  initial begin
    t_reset();
    t_signed_add();
    t_signed_sub();
    t_unsigned();
    t_double();
    t_word_clamp();
    t_dual();
    t_sticky();
    t_pass();
    t_mix();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule